// File: doc/BRIEF.md
# Triggered Sampling-Array Acquisition Sequencer

This block runs the digital side of a switched-capacitor waveform recorder. The recorder has four signal channels of 256 storage cells each, plus a reference channel that records the sampling window. Between events the write phase runs freely. A cell pointer steps through consecutive cells on every clock while writing is enabled, and wraps from the last cell back to cell 0. The sequencer tracks that pointer, so the circular record can later be unwrapped.

When a trigger is accepted, the sequencer latches the current cell index. It then keeps writing for a programmable number of post-trigger cycles, drops the write enable to freeze every cell of every channel, and issues a single start pulse that launches conversion of all cells at once. Conversion takes roughly 2 µs. Once the converter reports completion, writing resumes at once and readout is started in parallel. The dead time therefore depends only on conversion, and not on readout.

A trigger that arrives while an event is still being handled has no effect on the acquisition. It only advances a saturating count of lost triggers. When readout reports completion, the block is armed for the next trigger.

Top module: `sca_acq_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it: wr_en_o=1, busy_o=0, conv_start_o=0, read_start_o=0, stop_cell_o=0, lost_cnt_o=0.
- R2: wr_en_o is 0 only while waiting for conversion to finish. It is 1 while armed, during the post-trigger delay and during readout.
- R3: The cell pointer is 0 after reset and advances by one, modulo N_CELLS, at each clock edge where wr_en_o is 1. It holds its value while writing is frozen. An accepted trigger copies the pointer value at that edge to stop_cell_o.
- R4: If a trigger is accepted at edge t with delay value D, wr_en_o falls after edge t+D+1. conv_start_o is 1 for exactly that first frozen cycle.
- R5: Writing stays frozen until conv_done_i is sampled high. At the next edge wr_en_o returns to 1, and read_start_o is 1 for exactly that one cycle.
- R6: read_done_i sampled high during readout re-arms the block. conv_done_i and read_done_i have no effect in any other phase.
- R7: busy_o is 1 exactly during the post-trigger delay and while waiting for conversion.
- R8: A trigger sampled at any time other than when the block is armed does not restart the sequence and does not change stop_cell_o. It increments lost_cnt_o, which saturates at 2^LOST_W-1.
- R9: stop_dly_i is sampled only at the accepting trigger edge. Changes during the delay do not move the freeze point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Write clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Trigger, one event per cycle sampled high |
| conv_done_i | input | 1 | Converter finished all cells |
| read_done_i | input | 1 | Readout finished |
| stop_dly_i | input | DELAY_W | Post-trigger delay in write-clock cycles |
| wr_en_o | output | 1 | Write enable to the timing generator |
| conv_start_o | output | 1 | One-cycle pulse starting the ramp and conversion |
| read_start_o | output | 1 | One-cycle pulse starting readout |
| busy_o | output | 1 | Event in progress, not yet converted |
| stop_cell_o | output | CELL_W | Cell index latched at the accepted trigger |
| lost_cnt_o | output | LOST_W | Saturating count of ignored triggers |

## Verification
The bench targets the following corner cases, and what a wrong design would do in each:
- A zero delay and the largest delay. A design that is off by one would freeze the array a cycle early or late, and conv_start_o would fall on the wrong cycle.
- Triggers during conversion and during readout. A design that accepted them would overwrite stop_cell_o or restart the delay.
- Changes to the delay while it runs. A design that did not sample the delay only at the trigger would move the freeze point.
- Converter and readout done flags raised outside their own phase. A design that honoured them would skip a phase.
- Enough stray triggers to reach the top of the lost-trigger counter. A counter without saturation would wrap back to zero.
- Long random runs, which also carry the cell pointer across its wrap from the last cell back to 0.

// File: rtl/sca_acq_pkg.sv
package sca_acq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE_WR  = 2'd0,
    ST_POST_DLY = 2'd1,
    ST_CONVERT  = 2'd2,
    ST_READ_WR  = 2'd3
  } acq_state_e;
endpackage

// File: rtl/sca_wr_ptr.sv
module sca_wr_ptr #(
  parameter int N_CELLS = 256,
  localparam int CELL_W = $clog2(N_CELLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [CELL_W-1:0] ptr_o
);
  localparam logic [CELL_W-1:0] LAST = CELL_W'(N_CELLS - 1);

  logic [CELL_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ptr_q <= '0;
    else if (adv_i)      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/sca_post_dly.sv
module sca_post_dly #(
  parameter int DELAY_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [DELAY_W-1:0] val_i,
  input  logic               run_i,
  output logic               zero_o
);
  logic [DELAY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= val_i;
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sca_sat_cnt.sv
module sca_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (inc_i && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sca_acq_seq.sv
module sca_acq_seq
  import sca_acq_pkg::*;
#(
  parameter int N_CELLS = 256,
  parameter int DELAY_W = 8,
  parameter int LOST_W  = 8,
  localparam int CELL_W = $clog2(N_CELLS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trig_i,
  input  logic               conv_done_i,
  input  logic               read_done_i,
  input  logic [DELAY_W-1:0] stop_dly_i,
  output logic               wr_en_o,
  output logic               conv_start_o,
  output logic               read_start_o,
  output logic               busy_o,
  output logic [CELL_W-1:0]  stop_cell_o,
  output logic [LOST_W-1:0]  lost_cnt_o
);
  acq_state_e        state_q, state_d;
  logic              armed, trig_acc, trig_lost, dly_zero, wr_en;
  logic [CELL_W-1:0] ptr, stop_cell_q;
  logic              conv_start_q, read_start_q;

  assign armed     = (state_q == ST_IDLE_WR);
  assign trig_acc  = trig_i && armed;
  assign trig_lost = trig_i && !armed;
  assign wr_en     = (state_q != ST_CONVERT);

  sca_wr_ptr #(.N_CELLS(N_CELLS)) u_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (wr_en),
    .ptr_o (ptr)
  );

  sca_post_dly #(.DELAY_W(DELAY_W)) u_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(trig_acc),
    .val_i (stop_dly_i),
    .run_i (state_q == ST_POST_DLY),
    .zero_o(dly_zero)
  );

  sca_sat_cnt #(.W(LOST_W)) u_lost (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (trig_lost),
    .cnt_o (lost_cnt_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE_WR:  if (trig_i)      state_d = ST_POST_DLY;
      ST_POST_DLY: if (dly_zero)    state_d = ST_CONVERT;
      ST_CONVERT:  if (conv_done_i) state_d = ST_READ_WR;
      ST_READ_WR:  if (read_done_i) state_d = ST_IDLE_WR;
      default:                      state_d = ST_IDLE_WR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE_WR;
      stop_cell_q  <= '0;
      conv_start_q <= 1'b0;
      read_start_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      conv_start_q <= (state_q == ST_POST_DLY) && dly_zero;
      read_start_q <= (state_q == ST_CONVERT) && conv_done_i;
      if (trig_acc) stop_cell_q <= ptr;
    end
  end

  assign wr_en_o      = wr_en;
  assign busy_o       = (state_q == ST_POST_DLY) || (state_q == ST_CONVERT);
  assign conv_start_o = conv_start_q;
  assign read_start_o = read_start_q;
  assign stop_cell_o  = stop_cell_q;
endmodule

// File: rtl/sca_acq_seq_chk.sv
module sca_acq_seq_chk #(
  parameter int DELAY_W = 8,
  parameter int LOST_W  = 8,
  parameter int CELL_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_o,
  input logic              busy_o,
  input logic              conv_start_o,
  input logic              read_start_o,
  input logic [CELL_W-1:0] stop_cell_o,
  input logic [LOST_W-1:0] lost_cnt_o
);
  localparam int WIN_W = DELAY_W + 2;
  localparam logic [WIN_W-1:0] MAX_WIN = WIN_W'(2 ** DELAY_W);

  logic [WIN_W-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                win_q <= '0;
    else if (busy_o && wr_en_o) win_q <= win_q + 1'b1;
    else                        win_q <= '0;
  end

  AST_DLY_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_q <= MAX_WIN); // R4
  AST_CONV_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> (!wr_en_o && busy_o)); // R4
  AST_CONV_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o); // R4
  AST_READ_RESUMES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_start_o |-> (wr_en_o && !busy_o)); // R5
  AST_FROZEN_IS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_o |-> busy_o); // R7
  AST_STOP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(stop_cell_o)); // R8
  AST_LOST_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_cnt_o >= $past(lost_cnt_o)); // R8
endmodule

bind sca_acq_seq sca_acq_seq_chk #(
  .DELAY_W(DELAY_W),
  .LOST_W (LOST_W),
  .CELL_W (CELL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_o     (wr_en_o),
  .busy_o      (busy_o),
  .conv_start_o(conv_start_o),
  .read_start_o(read_start_o),
  .stop_cell_o (stop_cell_o),
  .lost_cnt_o  (lost_cnt_o)
);

// File: tb/sca_acq_seq_tb.sv
`timescale 1ns/1ps
module sca_acq_seq_tb;
  localparam int N_CELLS = 256;
  localparam int DELAY_W = 8;
  localparam int LOST_W  = 3;
  localparam int CELL_W  = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic trig_i = 1'b0, conv_done_i = 1'b0, read_done_i = 1'b0;
  logic [DELAY_W-1:0] stop_dly_i = '0;
  logic wr_en_o, conv_start_o, read_start_o, busy_o;
  logic [CELL_W-1:0] stop_cell_o;
  logic [LOST_W-1:0] lost_cnt_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  sca_acq_seq #(.N_CELLS(N_CELLS), .DELAY_W(DELAY_W), .LOST_W(LOST_W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig_i), .conv_done_i(conv_done_i),
    .read_done_i(read_done_i), .stop_dly_i(stop_dly_i), .wr_en_o(wr_en_o),
    .conv_start_o(conv_start_o), .read_start_o(read_start_o), .busy_o(busy_o),
    .stop_cell_o(stop_cell_o), .lost_cnt_o(lost_cnt_o)
  );

  // reference model: 0 armed, 1 delay, 2 convert, 3 read
  int m_st = 0, m_cnt = 0, m_ptr = 0, m_stop = 0, m_lost = 0;
  int m_cs = 0, m_rs = 0;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_st = 0; m_cnt = 0; m_ptr = 0; m_stop = 0; m_lost = 0; m_cs = 0; m_rs = 0;
    end else begin
      int st, cnt, ptr;
      st = m_st; cnt = m_cnt; ptr = m_ptr;
      m_cs = (st == 1 && cnt == 0) ? 1 : 0;
      m_rs = (st == 2 && conv_done_i) ? 1 : 0;
      if (st != 2) m_ptr = (ptr + 1) % N_CELLS;
      if (trig_i && st != 0 && m_lost < (1 << LOST_W) - 1) m_lost = m_lost + 1;
      case (st)
        0: if (trig_i) begin m_st = 1; m_cnt = int'(stop_dly_i); m_stop = ptr; end
        1: if (cnt == 0) m_st = 2; else m_cnt = cnt - 1;
        2: if (conv_done_i) m_st = 3;
        default: if (read_done_i) m_st = 0;
      endcase
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 wr_en_o", int'(wr_en_o), (m_st != 2) ? 1 : 0);
    chk("R7 busy_o", int'(busy_o), (m_st == 1 || m_st == 2) ? 1 : 0);
    chk("R4 conv_start_o", int'(conv_start_o), m_cs);
    chk("R5 read_start_o", int'(read_start_o), m_rs);
    chk("R3 stop_cell_o", int'(stop_cell_o), m_stop);
    chk("R8 lost_cnt_o", int'(lost_cnt_o), m_lost);
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    check_all();
    trig_i = 1'b0; conv_done_i = 1'b0; read_done_i = 1'b0;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R1 reset values
    chk("R1 wr_en_o", int'(wr_en_o), 1);
    chk("R1 busy_o", int'(busy_o), 0);
    chk("R1 conv_start_o", int'(conv_start_o), 0);
    chk("R1 read_start_o", int'(read_start_o), 0);
    chk("R1 stop_cell_o", int'(stop_cell_o), 0);
    chk("R1 lost_cnt_o", int'(lost_cnt_o), 0);
    rst_ni = 1'b1;
    steps(4);

    // R6: done flags while armed are ignored
    conv_done_i = 1'b1; read_done_i = 1'b1; step();
    chk("R6 wr_en_o armed", int'(wr_en_o), 1);
    chk("R6 busy_o armed", int'(busy_o), 0);

    // zero delay: freeze one cycle after the trigger edge
    trig_i = 1'b1; stop_dly_i = 8'd0; step();
    chk("R4 busy after trigger", int'(busy_o), 1);
    step();
    chk("R4 conv_start dly0", int'(conv_start_o), 1);
    // R8: trigger while converting, R6: read_done while converting
    trig_i = 1'b1; read_done_i = 1'b1; step();
    chk("R6 still frozen", int'(wr_en_o), 0);
    steps(3);
    conv_done_i = 1'b1; step();
    chk("R5 read_start", int'(read_start_o), 1);
    trig_i = 1'b1; conv_done_i = 1'b1; step();
    steps(2);
    read_done_i = 1'b1; step();

    // R9: delay changed mid-window does not move the freeze
    trig_i = 1'b1; stop_dly_i = 8'd2; step();
    stop_dly_i = 8'd7; step();
    stop_dly_i = 8'd0; step();
    chk("R9 still writing", int'(wr_en_o), 1);
    step();
    chk("R9 conv_start at D+1", int'(conv_start_o), 1);
    conv_done_i = 1'b1; step();
    read_done_i = 1'b1; step();

    // largest delay
    trig_i = 1'b1; stop_dly_i = 8'd255; step();
    steps(255);
    chk("R4 last delay cycle", int'(wr_en_o), 1);
    step();
    chk("R4 conv_start dly255", int'(conv_start_o), 1);
    conv_done_i = 1'b1; step();
    read_done_i = 1'b1; step();

    // constrained random
    for (int i = 0; i < 20000; i++) begin
      trig_i      = ($urandom % 6) == 0;
      conv_done_i = ($urandom % 5) == 0;
      read_done_i = ($urandom % 7) == 0;
      if (($urandom % 40) == 0) stop_dly_i = DELAY_W'($urandom);
      else                      stop_dly_i = DELAY_W'($urandom % 6);
      step();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule